// File: doc/BRIEF.md
# Capability-Checked Load/Store Unit

This block executes the memory access instructions that reach memory through a capability. It takes one instruction word at a time and decodes it. It reads the operand registers through combinational read ports and forms a virtual address. In default-capability mode that address is the default capability's base plus an integer register. In capability-register mode it is the cursor of a capability register.

Before anything touches memory, a fixed-priority set of capability checks runs, followed by an alignment check. Every failure has its own cause code. When all checks pass, the unit issues exactly one request on a valid/ready memory port with the access size, and for stores the data trimmed to that size. Load data that comes back is sign- or zero-extended and written to the destination integer register. Address translation and the memory sit outside the block, behind that request/response port.

The unit accepts an instruction in any cycle where `instReady` is high. It returns `instReady` once the access has finished or been refused.

Top module: `cap_lsu`

## Requirements
- R1: An instruction is accepted only when bits 6:0 are 1011011, bits 14:12 are 000 and bits 31:25 are 0000000, and the operation code in bits 24:20 is not a store with bit 2 set. Any other word is ignored: it produces no memory request, no exception and no write-back.
- R2: The operation code in bits 24:20 is decoded as follows. Bit 4 = 1 selects capability-register mode, with the register index in bits 19:15. Bit 4 = 0 selects default-capability mode, with the integer register in bits 19:15. In default-capability mode the address is the default base plus that integer register, modulo 2^XLEN. In capability-register mode the address is the cursor of the selected capability. Capability index 0 means the default capability, not a null capability.
- R3: Capability checks are taken in strict priority, first failure only. Tag clear gives cause 1. Sealed gives cause 2. Missing load permission on a load, or missing store permission on a store, gives cause 3. Address + size above top, or address below base, gives cause 4. A refused access issues no memory request.
- R4: The upper-bound test uses an XLEN+1-bit sum, so it never wraps. An access that ends exactly at top passes. Top may be 2^XLEN.
- R5: Alignment is checked only after every capability check passes. A misaligned load gives cause 5 and a misaligned store gives cause 6.
- R6: With an exception, `excCapIdx` carries the capability index from bits 19:15 in capability-register mode, and 0 in default-capability mode. `excAddr` carries the virtual address.
- R7: After a passing check, `memReqValid` is held with stable address, size, direction and data until `memReqReady` is sampled high. Exactly one request is made per instruction.
- R8: The width code in bits 1:0 of the operation code (00/01/10/11 = 1/2/4/8 bytes) is placed on `memReqSize`. A store sends only the low 8/16/32/64 bits of the integer register named by bits 11:7, with all higher bits zero.
- R9: Bit 2 of the operation code selects zero-extension (1) or sign-extension (0) of load data. An 8-byte load gives the same result either way.
- R10: A response with `memRspFault` high raises cause 7 with the access address and writes no register.
- R11: A successful load writes the register named by bits 11:7. A destination of 0 and every exception produce no write-back.
- R12: With the instruction accepted at edge E, a check exception pulses `excValid` for one cycle after edge E+1. A load with a response sampled at edge F pulses `wbValid` for one cycle after edge F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word offered |
| instWord | input | 32 | Instruction word |
| instReady | output | 1 | Unit idle, can accept |
| intRdIdxA | output | 5 | Integer read index, address operand (bits 19:15) |
| intRdDataA | input | XLEN | Integer read data for index A |
| intRdIdxB | output | 5 | Integer read index, store data (bits 11:7) |
| intRdDataB | input | XLEN | Integer read data for index B |
| capRdIdx | output | 5 | Capability read index (bits 19:15) |
| capTag | input | 1 | Selected capability valid tag |
| capSealed | input | 1 | Selected capability sealed |
| capPermLoad | input | 1 | Selected capability load permission |
| capPermStore | input | 1 | Selected capability store permission |
| capBase | input | XLEN | Selected capability base |
| capTop | input | XLEN+1 | Selected capability top (exclusive) |
| capCursor | input | XLEN | Selected capability cursor |
| defTag | input | 1 | Default capability tag |
| defSealed | input | 1 | Default capability sealed |
| defPermLoad | input | 1 | Default capability load permission |
| defPermStore | input | 1 | Default capability store permission |
| defBase | input | XLEN | Default capability base |
| defTop | input | XLEN+1 | Default capability top |
| defCursor | input | XLEN | Default capability cursor |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request taken |
| memReqWrite | output | 1 | 1 = store, 0 = load |
| memReqAddr | output | XLEN | Virtual address |
| memReqSize | output | 2 | Width code |
| memReqWData | output | XLEN | Store data, trimmed |
| memRspValid | input | 1 | Memory response valid |
| memRspFault | input | 1 | Translation or access fault |
| memRspData | input | XLEN | Load data |
| excValid | output | 1 | Exception pulse |
| excCause | output | 4 | Exception cause (1..7) |
| excCapIdx | output | 5 | Offending capability index |
| excAddr | output | XLEN | Faulting virtual address |
| wbValid | output | 1 | Write-back pulse |
| wbIdx | output | 5 | Destination integer register |
| wbData | output | XLEN | Extended load data |

## Verification
The assertions take three things for granted about the environment:
- A memory response arrives only after the request has been taken, and never in the same cycle as `memReqReady`.
- The register and capability read data are valid in the cycle the instruction is accepted.
- The memory side never raises `memRspValid` while no access is outstanding.

The bench plays the memory with a single task. That task raises ready only while a request is visible, drives the response alone in the following cycle, and drives the operand arrays as combinational reads of the index outputs. It never offers a second instruction before the previous one has settled.

// File: rtl/cap_lsu_pkg.sv
package cap_lsu_pkg;

  localparam int IDX_W = 5;
  localparam logic [6:0] LSU_MAJOR_OP = 7'b1011011;

  typedef enum logic [3:0] {
    EXC_NONE        = 4'd0,
    EXC_TAG         = 4'd1,
    EXC_SEAL        = 4'd2,
    EXC_PERM        = 4'd3,
    EXC_LENGTH      = 4'd4,
    EXC_LOAD_ALIGN  = 4'd5,
    EXC_STORE_ALIGN = 4'd6,
    EXC_MEM_FAULT   = 4'd7
  } excCause_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_RSP
  } lsuState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch decoded instruction and operands
    logic checkExc;   // report the check result as an exception
    logic memExc;     // report a faulted memory response
    logic accessDone; // response arrived without fault
  } dpStrobe_t;

endpackage

// File: rtl/cap_lsu_check.sv
module cap_lsu_check
  import cap_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            tag,
  input  logic            sealed,
  input  logic            permLoad,
  input  logic            permStore,
  input  logic            isStore,
  input  logic [1:0]      width,
  input  logic [XLEN-1:0] vaddr,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN:0]   top,
  output excCause_e       cause
);
  localparam int AW = XLEN + 1;

  logic [3:0]    sizeBytes;
  logic [AW-1:0] endAddr;
  logic          misaligned;

  always_comb begin
    sizeBytes  = 4'd1 << width;
    endAddr    = {1'b0, vaddr} + AW'(sizeBytes);
    misaligned = |(vaddr[2:0] & (sizeBytes[2:0] - 3'd1));
    cause      = EXC_NONE;
    if (!tag)                                 cause = EXC_TAG;
    else if (sealed)                          cause = EXC_SEAL;
    else if (isStore ? !permStore : !permLoad) cause = EXC_PERM;
    else if (endAddr > top)                   cause = EXC_LENGTH;
    else if (vaddr < base)                    cause = EXC_LENGTH;
    else if (misaligned)                      cause = isStore ? EXC_STORE_ALIGN : EXC_LOAD_ALIGN;
  end

endmodule

// File: rtl/cap_lsu_ctrl.sv
module cap_lsu_ctrl
  import cap_lsu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  logic      instLegal,
  input  logic      checkPass,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      memRspFault,
  output logic      instReady,
  output logic      memReqValid,
  output dpStrobe_t ctl
);
  lsuState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    instReady   = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        instReady = 1'b1;
        if (instValid && instLegal) begin
          ctl.capture = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (checkPass) stateNext = ST_REQ;
        else begin
          ctl.checkExc = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_RSP;
      end
      ST_RSP: begin
        if (memRspValid) begin
          ctl.memExc     = memRspFault;
          ctl.accessDone = !memRspFault;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R7: a raised request is not withdrawn before it is taken
  a_r7_req_held : assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R12: an accepted instruction makes the unit busy in the next cycle
  a_r12_busy_after_accept : assert property (@(posedge clk) disable iff (!rstN)
    instValid && instLegal && instReady |=> !instReady);

endmodule

// File: rtl/cap_lsu_dp.sv
module cap_lsu_dp
  import cap_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        ctl,
  input  logic             memReqValid,
  input  logic [31:0]      instWord,
  output logic             instLegal,
  output logic [IDX_W-1:0] intRdIdxA,
  input  logic [XLEN-1:0]  intRdDataA,
  output logic [IDX_W-1:0] intRdIdxB,
  input  logic [XLEN-1:0]  intRdDataB,
  output logic [IDX_W-1:0] capRdIdx,
  input  logic             capTag,
  input  logic             capSealed,
  input  logic             capPermLoad,
  input  logic             capPermStore,
  input  logic [XLEN-1:0]  capBase,
  input  logic [XLEN:0]    capTop,
  input  logic [XLEN-1:0]  capCursor,
  input  logic             defTag,
  input  logic             defSealed,
  input  logic             defPermLoad,
  input  logic             defPermStore,
  input  logic [XLEN-1:0]  defBase,
  input  logic [XLEN:0]    defTop,
  input  logic [XLEN-1:0]  defCursor,
  output logic             checkPass,
  output logic             memReqWrite,
  output logic [XLEN-1:0]  memReqAddr,
  output logic [1:0]       memReqSize,
  output logic [XLEN-1:0]  memReqWData,
  input  logic [XLEN-1:0]  memRspData,
  output logic             excValid,
  output excCause_e        excCause,
  output logic [IDX_W-1:0] excCapIdx,
  output logic [XLEN-1:0]  excAddr,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [XLEN-1:0]  wbData
);
  localparam int NBYTES = XLEN / 8;

  // decode
  logic [4:0] opSel;
  logic [4:0] fieldA;
  logic [4:0] fieldD;
  logic       useDef;

  assign opSel  = instWord[24:20];
  assign fieldA = instWord[19:15];
  assign fieldD = instWord[11:7];
  assign instLegal = (instWord[6:0] == LSU_MAJOR_OP) && (instWord[14:12] == 3'b000) &&
                     (instWord[31:25] == 7'b0) && !(opSel[3] && opSel[2]);
  assign useDef    = !opSel[4] || (fieldA == '0);
  assign intRdIdxA = fieldA;
  assign intRdIdxB = fieldD;
  assign capRdIdx  = fieldA;

  // captured instruction state
  logic             storeQ, unsQ, tagQ, sealQ, permLdQ, permStQ;
  logic [1:0]       widthQ;
  logic [IDX_W-1:0] rdQ, repIdxQ;
  logic [XLEN-1:0]  vaddrQ, baseQ, dataQ;
  logic [XLEN:0]    topQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeQ <= 1'b0; unsQ <= 1'b0; tagQ <= 1'b0; sealQ <= 1'b0;
      permLdQ <= 1'b0; permStQ <= 1'b0; widthQ <= '0; rdQ <= '0; repIdxQ <= '0;
      vaddrQ <= '0; baseQ <= '0; dataQ <= '0; topQ <= '0;
    end else if (ctl.capture) begin
      storeQ  <= opSel[3];
      unsQ    <= opSel[2];
      widthQ  <= opSel[1:0];
      rdQ     <= fieldD;
      repIdxQ <= opSel[4] ? fieldA : '0;
      vaddrQ  <= opSel[4] ? (useDef ? defCursor : capCursor) : (defBase + intRdDataA);
      tagQ    <= useDef ? defTag       : capTag;
      sealQ   <= useDef ? defSealed    : capSealed;
      permLdQ <= useDef ? defPermLoad  : capPermLoad;
      permStQ <= useDef ? defPermStore : capPermStore;
      baseQ   <= useDef ? defBase      : capBase;
      topQ    <= useDef ? defTop       : capTop;
      dataQ   <= intRdDataB;
    end
  end

  excCause_e chkCause;

  cap_lsu_check #(.XLEN(XLEN)) u_check (
    .tag      (tagQ),
    .sealed   (sealQ),
    .permLoad (permLdQ),
    .permStore(permStQ),
    .isStore  (storeQ),
    .width    (widthQ),
    .vaddr    (vaddrQ),
    .base     (baseQ),
    .top      (topQ),
    .cause    (chkCause)
  );

  assign checkPass = (chkCause == EXC_NONE);

  // request fields and store-data trimming
  logic [XLEN-1:0] byteMask;
  always_comb begin
    for (int b = 0; b < NBYTES; b++)
      byteMask[b*8 +: 8] = (b < (1 << widthQ)) ? 8'hFF : 8'h00;
  end

  assign memReqWrite = storeQ;
  assign memReqAddr  = vaddrQ;
  assign memReqSize  = widthQ;
  assign memReqWData = dataQ & byteMask;

  // load extension
  logic [XLEN-1:0] loadExt;
  always_comb begin
    case (widthQ)
      2'd0:    loadExt = {{(XLEN-8){!unsQ && memRspData[7]}},   memRspData[7:0]};
      2'd1:    loadExt = {{(XLEN-16){!unsQ && memRspData[15]}}, memRspData[15:0]};
      2'd2:    loadExt = {{(XLEN-32){!unsQ && memRspData[31]}}, memRspData[31:0]};
      default: loadExt = memRspData;
    endcase
  end

  // result outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid  <= 1'b0;
      excCause  <= EXC_NONE;
      excCapIdx <= '0;
      excAddr   <= '0;
      wbValid   <= 1'b0;
      wbIdx     <= '0;
      wbData    <= '0;
    end else begin
      excValid <= ctl.checkExc || ctl.memExc;
      wbValid  <= ctl.accessDone && !storeQ && (rdQ != '0);
      if (ctl.checkExc || ctl.memExc) begin
        excCause  <= ctl.memExc ? EXC_MEM_FAULT : chkCause;
        excCapIdx <= repIdxQ;
        excAddr   <= vaddrQ;
      end
      if (ctl.accessDone && !storeQ && (rdQ != '0)) begin
        wbIdx  <= rdQ;
        wbData <= loadExt;
      end
    end
  end

  // R7: a request only ever follows a fully passing check
  a_r7_req_after_pass : assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> checkPass);

  // R10: a faulted response is reported as cause 7
  a_r10_fault_reported : assert property (@(posedge clk) disable iff (!rstN)
    ctl.memExc |=> excValid && excCause == EXC_MEM_FAULT);

  // R11: register 0 is never written, exception and write-back are exclusive
  a_r11_no_wb_zero : assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbIdx != '0) && !excValid);

  // R5: an alignment cause implies a misaligned address
  a_r5_align_cause : assert property (@(posedge clk) disable iff (!rstN)
    excValid && (excCause == EXC_LOAD_ALIGN || excCause == EXC_STORE_ALIGN)
      |-> (excAddr[2:0] & ((3'd1 << widthQ) - 3'd1)) != 3'd0);

endmodule

// File: rtl/cap_lsu.sv
module cap_lsu
  import cap_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  output logic            instReady,
  output logic [4:0]      intRdIdxA,
  input  logic [XLEN-1:0] intRdDataA,
  output logic [4:0]      intRdIdxB,
  input  logic [XLEN-1:0] intRdDataB,
  output logic [4:0]      capRdIdx,
  input  logic            capTag,
  input  logic            capSealed,
  input  logic            capPermLoad,
  input  logic            capPermStore,
  input  logic [XLEN-1:0] capBase,
  input  logic [XLEN:0]   capTop,
  input  logic [XLEN-1:0] capCursor,
  input  logic            defTag,
  input  logic            defSealed,
  input  logic            defPermLoad,
  input  logic            defPermStore,
  input  logic [XLEN-1:0] defBase,
  input  logic [XLEN:0]   defTop,
  input  logic [XLEN-1:0] defCursor,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [XLEN-1:0] memReqAddr,
  output logic [1:0]      memReqSize,
  output logic [XLEN-1:0] memReqWData,
  input  logic            memRspValid,
  input  logic            memRspFault,
  input  logic [XLEN-1:0] memRspData,
  output logic            excValid,
  output logic [3:0]      excCause,
  output logic [4:0]      excCapIdx,
  output logic [XLEN-1:0] excAddr,
  output logic            wbValid,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData
);
  dpStrobe_t ctl;
  logic      instLegal;
  logic      checkPass;
  excCause_e causeInt;

  cap_lsu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instLegal  (instLegal),
    .checkPass  (checkPass),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memRspFault(memRspFault),
    .instReady  (instReady),
    .memReqValid(memReqValid),
    .ctl        (ctl)
  );

  cap_lsu_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memReqValid(memReqValid),
    .instWord(instWord), .instLegal(instLegal),
    .intRdIdxA(intRdIdxA), .intRdDataA(intRdDataA),
    .intRdIdxB(intRdIdxB), .intRdDataB(intRdDataB),
    .capRdIdx(capRdIdx), .capTag(capTag), .capSealed(capSealed),
    .capPermLoad(capPermLoad), .capPermStore(capPermStore),
    .capBase(capBase), .capTop(capTop), .capCursor(capCursor),
    .defTag(defTag), .defSealed(defSealed),
    .defPermLoad(defPermLoad), .defPermStore(defPermStore),
    .defBase(defBase), .defTop(defTop), .defCursor(defCursor),
    .checkPass(checkPass),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqSize(memReqSize), .memReqWData(memReqWData),
    .memRspData(memRspData),
    .excValid(excValid), .excCause(causeInt), .excCapIdx(excCapIdx), .excAddr(excAddr),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData)
  );

  assign excCause = causeInt;

  // R7: request fields stay put while the memory side stalls
  a_r7_req_stable : assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) &&
      $stable(memReqSize) && $stable(memReqWrite) && $stable(memReqWData));

  // R12: result pulses last a single cycle
  a_r12_single_pulse : assert property (@(posedge clk) disable iff (!rstN)
    excValid || wbValid |=> !excValid && !wbValid);

endmodule

// File: tb/cap_lsu_tb.sv
module cap_lsu_tb;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic            instValid = 1'b0;
  logic [31:0]     instWord = '0;
  logic            instReady;
  logic [4:0]      intRdIdxA, intRdIdxB, capRdIdx;
  logic [XLEN-1:0] intRdDataA, intRdDataB;
  logic            capTag, capSealed, capPermLoad, capPermStore;
  logic [XLEN-1:0] capBase, capCursor;
  logic [XLEN:0]   capTop;
  logic            defTag = 1'b1, defSealed = 1'b0, defPermLoad = 1'b1, defPermStore = 1'b1;
  logic [XLEN-1:0] defBase = 64'h1000, defCursor = 64'h1800;
  logic [XLEN:0]   defTop = 65'h2000;
  logic            memReqValid, memReqWrite;
  logic            memReqReady = 1'b0;
  logic [XLEN-1:0] memReqAddr, memReqWData;
  logic [1:0]      memReqSize;
  logic            memRspValid = 1'b0, memRspFault = 1'b0;
  logic [XLEN-1:0] memRspData = '0;
  logic            excValid, wbValid;
  logic [3:0]      excCause;
  logic [4:0]      excCapIdx, wbIdx;
  logic [XLEN-1:0] excAddr, wbData;

  // register models read combinationally through the index outputs
  logic [XLEN-1:0] xr [32];
  logic            cT [32], cS [32], cPL [32], cPS [32];
  logic [XLEN-1:0] cB [32], cC [32];
  logic [XLEN:0]   cTop [32];

  assign intRdDataA   = xr[intRdIdxA];
  assign intRdDataB   = xr[intRdIdxB];
  assign capTag       = cT[capRdIdx];
  assign capSealed    = cS[capRdIdx];
  assign capPermLoad  = cPL[capRdIdx];
  assign capPermStore = cPS[capRdIdx];
  assign capBase      = cB[capRdIdx];
  assign capTop       = cTop[capRdIdx];
  assign capCursor    = cC[capRdIdx];

  cap_lsu #(.XLEN(XLEN)) u_dut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [XLEN:0] act, input logic [XLEN:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] sel, input logic [4:0] fa, input logic [4:0] fd);
    return {7'b0, sel, fa, 3'b000, fd, 7'b1011011};
  endfunction

  task automatic setCap(input int i, input logic t, input logic s, input logic pl, input logic ps,
                        input logic [63:0] b, input logic [64:0] tp, input logic [63:0] c);
    cT[i] = t; cS[i] = s; cPL[i] = pl; cPS[i] = ps; cB[i] = b; cTop[i] = tp; cC[i] = c;
  endtask

  // records of one operation
  int              reqCnt, excCnt, excAt, wbCnt, wbAt;
  logic            stableOk, endReady;
  logic [3:0]      exC;
  logic [4:0]      exI, wbI;
  logic [XLEN-1:0] exA, wbD, rA, rD;
  logic [1:0]      rS;
  logic            rW;

  task automatic doOp(input logic [31:0] word, input int rdyDelay, input logic fault, input logic [63:0] rdata);
    int   waitCnt;
    logic accLast;
    logic reqSeen;
    reqCnt = 0; excCnt = 0; excAt = 0; wbCnt = 0; wbAt = 0; stableOk = 1'b1;
    waitCnt = 0; accLast = 1'b0; reqSeen = 1'b0;
    @(negedge clk);
    instWord = word; instValid = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      instValid = 1'b0;
      if (excValid) begin
        excCnt++; if (excAt == 0) excAt = i;
        exC = excCause; exI = excCapIdx; exA = excAddr;
      end
      if (wbValid) begin
        wbCnt++; if (wbAt == 0) wbAt = i;
        wbI = wbIdx; wbD = wbData;
      end
      memRspValid = 1'b0; memRspFault = 1'b0;
      if (accLast) begin
        memRspValid = 1'b1; memRspFault = fault; memRspData = rdata; accLast = 1'b0;
      end
      if (memReqValid) begin
        if (reqSeen && (memReqAddr !== rA || memReqWData !== rD || memReqSize !== rS || memReqWrite !== rW))
          stableOk = 1'b0;
        reqSeen = 1'b1;
        rA = memReqAddr; rD = memReqWData; rS = memReqSize; rW = memReqWrite;
        if (waitCnt == rdyDelay) begin memReqReady = 1'b1; accLast = 1'b1; reqCnt++; end
        else begin memReqReady = 1'b0; waitCnt++; end
      end else memReqReady = 1'b0;
    end
    endReady = instReady;
  endtask

  task automatic t_reset;
    chk("R12 reset instReady", instReady, 1);
    chk("R7 reset memReqValid", memReqValid, 0);
    chk("R12 reset excValid", excValid, 0);
    chk("R11 reset wbValid", wbValid, 0);
  endtask

  task automatic t_def_load;
    xr[5] = 64'h10;
    doOp(enc(5'b00000, 5, 7), 0, 0, 64'h80);
    chk("R2 default-mode address", rA, 64'h1010);
    chk("R8 byte size code", rS, 0);
    chk("R9 signed byte", wbD, 64'hFFFF_FFFF_FFFF_FF80);
    chk("R11 write-back index", wbI, 7);
    chk("R12 wb timing", wbAt, 4);
    chk("R12 wb single pulse", wbCnt, 1);
    chk("R7 one request", reqCnt, 1);
    chk("R12 ready after load", endReady, 1);
  endtask

  task automatic t_extend;
    setCap(3, 1, 0, 1, 1, 64'h3000, 65'h4000, 64'h3002);
    doOp(enc(5'b10101, 3, 8), 0, 0, 64'hABCD_8001);
    chk("R9 zero half", wbD, 64'h8001);
    chk("R2 cursor address", rA, 64'h3002);
    cC[3] = 64'h3004;
    doOp(enc(5'b10010, 3, 8), 0, 0, 64'h1_8000_0000);
    chk("R9 signed word", wbD, 64'hFFFF_FFFF_8000_0000);
    doOp(enc(5'b10110, 3, 8), 0, 0, 64'h1_8000_0000);
    chk("R9 zero word", wbD, 64'h8000_0000);
    cC[3] = 64'h3008;
    doOp(enc(5'b10011, 3, 8), 0, 0, 64'h8000_0000_0000_0001);
    chk("R9 signed double", wbD, 64'h8000_0000_0000_0001);
    doOp(enc(5'b10111, 3, 8), 0, 0, 64'h8000_0000_0000_0001);
    chk("R9 zero double equal", wbD, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_store;
    xr[9] = 64'h1122_3344_5566_7788;
    doOp(enc(5'b01010, 5, 9), 0, 0, 0);
    chk("R8 word store data", rD, 64'h5566_7788);
    chk("R8 store direction", rW, 1);
    chk("R8 word size", rS, 2);
    chk("R11 no wb on store", wbCnt, 0);
    cC[3] = 64'h3001;
    doOp(enc(5'b11000, 3, 9), 0, 0, 0);
    chk("R8 byte store data", rD, 64'h88);
    cC[3] = 64'h3008;
    doOp(enc(5'b11011, 3, 9), 0, 0, 0);
    chk("R8 double store data", rD, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_priority;
    setCap(4, 0, 1, 0, 0, 64'h4000, 65'h5000, 64'h5001);
    doOp(enc(5'b10010, 4, 8), 0, 0, 0);
    chk("R3 tag first", exC, 1);
    chk("R6 cap index", exI, 4);
    chk("R6 exc address", exA, 64'h5001);
    chk("R12 exc timing", excAt, 2);
    chk("R12 exc single pulse", excCnt, 1);
    chk("R3 no request on refusal", reqCnt, 0);
    cT[4] = 1;
    doOp(enc(5'b10010, 4, 8), 0, 0, 0);
    chk("R3 seal second", exC, 2);
    cS[4] = 0;
    doOp(enc(5'b10010, 4, 8), 0, 0, 0);
    chk("R3 permission third", exC, 3);
    cPL[4] = 1;
    doOp(enc(5'b10010, 4, 8), 0, 0, 0);
    chk("R3 length before alignment", exC, 4);
    cC[4] = 64'h4000;
    doOp(enc(5'b11010, 4, 9), 0, 0, 0);
    chk("R3 store needs store permission", exC, 3);
    cPS[4] = 1;
    cC[4] = 64'h3FFC;
    doOp(enc(5'b10010, 4, 8), 0, 0, 0);
    chk("R3 below base", exC, 4);
  endtask

  task automatic t_bounds;
    cC[4] = 64'h4FFC;
    doOp(enc(5'b10010, 4, 8), 0, 0, 64'h5);
    chk("R4 access ending at top passes", reqCnt, 1);
    cC[4] = 64'h5000;
    doOp(enc(5'b10000, 4, 8), 0, 0, 0);
    chk("R4 byte at top refused", exC, 4);
    setCap(6, 1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_F000, 65'h1_0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF8);
    doOp(enc(5'b10011, 6, 8), 0, 0, 0);
    chk("R4 top of space passes", reqCnt, 1);
    cC[6] = 64'hFFFF_FFFF_FFFF_FFFC;
    doOp(enc(5'b10011, 6, 8), 0, 0, 0);
    chk("R4 no wrap in sum", exC, 4);
    chk("R4 no request on wrap", reqCnt, 0);
  endtask

  task automatic t_align;
    cC[4] = 64'h4001;
    doOp(enc(5'b10001, 4, 8), 0, 0, 0);
    chk("R5 load alignment", exC, 5);
    doOp(enc(5'b11001, 4, 9), 0, 0, 0);
    chk("R5 store alignment", exC, 6);
    cT[4] = 0;
    doOp(enc(5'b10001, 4, 8), 0, 0, 0);
    chk("R5 tag beats alignment", exC, 1);
    cT[4] = 1;
  endtask

  task automatic t_def_idx;
    defTag = 0;
    doOp(enc(5'b00000, 5, 7), 0, 0, 0);
    chk("R6 default mode index", exI, 0);
    chk("R6 default mode address", exA, 64'h1010);
    defTag = 1;
    doOp(enc(5'b10011, 0, 7), 0, 0, 64'h77);
    chk("R2 index 0 is default", rA, 64'h1800);
    chk("R2 index 0 load result", wbD, 64'h77);
    defBase = 64'hFFFF_FFFF_FFFF_FFF0; defTop = 65'h1_0000_0000_0000_0000; xr[10] = 64'h20;
    doOp(enc(5'b00100, 10, 7), 0, 0, 0);
    chk("R2 address modulo", exA, 64'h10);
    chk("R2 wrapped address below base", exC, 4);
    defBase = 64'h1000; defTop = 65'h2000;
  endtask

  task automatic t_fault_rd0;
    doOp(enc(5'b00000, 5, 7), 0, 1, 64'h55);
    chk("R10 fault cause", exC, 7);
    chk("R10 fault address", exA, 64'h1010);
    chk("R10 no wb on fault", wbCnt, 0);
    doOp(enc(5'b00000, 5, 0), 0, 0, 64'h55);
    chk("R11 rd zero issued", reqCnt, 1);
    chk("R11 rd zero discarded", wbCnt, 0);
  endtask

  task automatic t_illegal;
    doOp({7'b0, 5'b00000, 5'd5, 3'b000, 5'd7, 7'b0110011}, 0, 0, 0);
    chk("R1 wrong opcode no request", reqCnt + excCnt + wbCnt, 0);
    doOp({7'b0, 5'b01100, 5'd5, 3'b000, 5'd7, 7'b1011011}, 0, 0, 0);
    chk("R1 unsigned store ignored", reqCnt + excCnt + wbCnt, 0);
    doOp({7'b0, 5'b00000, 5'd5, 3'b001, 5'd7, 7'b1011011}, 0, 0, 0);
    chk("R1 funct3 mismatch ignored", reqCnt + excCnt + wbCnt, 0);
    doOp({7'b0000001, 5'b00000, 5'd5, 3'b000, 5'd7, 7'b1011011}, 0, 0, 0);
    chk("R1 funct7 mismatch ignored", reqCnt + excCnt + wbCnt, 0);
    chk("R1 ready stays high", endReady, 1);
  endtask

  task automatic t_wait;
    doOp(enc(5'b00000, 5, 7), 3, 0, 64'h7F);
    chk("R7 stable while stalled", stableOk, 1);
    chk("R7 single request", reqCnt, 1);
    chk("R12 wb after stalled response", wbAt, 7);
    chk("R9 positive byte", wbD, 64'h7F);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      xr[i] = '0;
      setCap(i, 0, 0, 0, 0, '0, '0, '0);
    end
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    t_def_load;
    t_extend;
    t_store;
    t_priority;
    t_bounds;
    t_align;
    t_def_idx;
    t_fault_rd0;
    t_illegal;
    t_wait;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule